// File: doc/BRIEF.md
# Multislope Result Accumulator

This block builds the signed conversion result of a multislope integrating converter. A separate sequencer runs the deintegrate phases. Each clock, it tells this block which phase is active, whether that clock counts, and which way the integrator is being driven. The block keeps a running signed count. The step size per counted clock depends on the phase. The first deintegrate phase is the coarsest, and each later phase is eight times finer.

When the sequencer marks the end of a conversion, the running count is copied into a result register. The copy is clamped to the converter's hard overrange magnitude. The result is presented as a 20-bit two's complement word whose top bit is the polarity. A one-cycle flag marks each new result, so that readout logic can detect a result changing under a read. A start pulse clears the running count before each new conversion.

Top module: `msr_result_acc`

## Requirements
- R1: After a synchronous active-low reset, the running count and `result` are zero and `result_new` is 0.
- R2: When `phase` is 1 (first deintegrate) and `cnt_en` is 1, each clock changes the running count by 512: it adds 512 when `cnt_down` is 0 and subtracts 512 when `cnt_down` is 1.
- R3: When `cnt_en` is 1, `phase` 2, 3 and 4 change the running count by 64, 8 and 1 per clock respectively, in the direction set by `cnt_down`.
- R4: The running count is unchanged on any clock where `cnt_en` is 0, or where `phase` is 0, 5, 6 or 7.
- R5: `conv_start` sets the running count to zero on the next edge. It takes priority over any count requested in the same cycle.
- R6: On a clock with `conv_end` high, `result` takes the running count as it stood before that edge. On all other clocks, `result` holds its value. When `conv_start` is also high, the old count is transferred and then cleared.
- R7: A running count above +350440 is reported as +350440. A running count below -350440 is reported as -350440.
- R8: `result` is 20-bit two's complement. Bits 18..0 are the magnitude-bearing bits B18..B0, and bit 19 is the polarity: 1 for a negative value.
- R9: `result_new` is 1 for exactly the cycle in which a transferred value first appears on `result`, and 0 otherwise.
- R10: The running count saturates at ±(2^21 - 1) (width 22) instead of wrapping. After saturating, counting in the opposite direction continues from the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Clear the running count for a new conversion |
| conv_end | input | 1 | Transfer the running count into the result register |
| phase | input | 3 | Active phase code: 1..4 = deintegrate phases 1..4, other values do not count |
| cnt_en | input | 1 | Count on this clock |
| cnt_down | input | 1 | Direction: 0 adds the phase weight, 1 subtracts it |
| result | output | 20 | Clamped two's complement result, bit 19 = polarity |
| result_new | output | 1 | One-cycle pulse marking a newly transferred result |

## Verification
The hardest state to reach is saturation of the running count itself. Clamping of the result hides it, because any count beyond 350440 reads the same at the ports. The stimulus drives more than four thousand coarse up-steps so that the count pins at its width limit. It then counts down by a known amount and transfers the result. A wrapping counter would give a visibly different value. Transfer and clear in the same cycle are also driven together, to show that the old count still reaches the result.

// File: rtl/msr_acc_pkg.sv
// Package: shared constants for the multislope result accumulator.
// Assumes phase code 0 means "no counting phase", and codes 1..NUM_DEINT
// name the deintegrate phases from coarsest to finest.
package msr_acc_pkg;
    localparam int PHASE_W    = 3;
    localparam int NUM_DEINT  = 4;
    localparam int COARSE_SH  = 9;   // first phase weight is 2**9
    localparam int FINER_SH   = 3;   // each later phase is 8x finer
    localparam int ACC_W      = 22;
    localparam int RES_W      = 20;
    localparam int HARD_LIMIT = 350440;

    typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/msr_step_weight.sv
// Module: msr_step_weight
// Decodes the phase code into the per-clock step magnitude.
// Assumes at most one deintegrate phase is named by a code; unnamed codes
// give step_hit = 0, and the accumulator then holds its count.
module msr_step_weight
    import msr_acc_pkg::*;
#(
    parameter int W         = ACC_W,
    parameter int N_PH      = NUM_DEINT,
    parameter int TOP_SH    = COARSE_SH,
    parameter int STEP_SH   = FINER_SH
) (
    input  phase_t         phase_code,
    output logic [W-1:0]   step_mag,
    output logic           step_hit
);
    logic [N_PH-1:0] hit;
    logic [W-1:0]    wt [N_PH];

    // One decoder and one constant weight per deintegrate phase.
    for (genvar i = 0; i < N_PH; i++) begin : g_phase
        localparam int SH = TOP_SH - i * STEP_SH;
        assign hit[i] = (phase_code == PHASE_W'(i + 1));
        assign wt[i]  = W'(1) << SH;
    end

    // Combine the phase weights; only the matching phase contributes.
    always_comb begin
        step_mag = '0;
        for (int i = 0; i < N_PH; i++) begin
            if (hit[i]) step_mag = step_mag | wt[i];
        end
        step_hit = |hit;
    end
endmodule

// File: rtl/msr_updown_acc.sv
// Module: msr_updown_acc
// Signed up/down running count with saturation at +/-(2**(W-1)-1).
// Assumes clr has priority over counting in the same cycle.
module msr_updown_acc
    import msr_acc_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cnt,
    input  logic                down,
    input  logic [W-1:0]        step,
    output logic signed [W-1:0] acc
);
    localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] MINV = -MAXV;

    logic signed [W:0] ext;
    logic signed [W:0] stepx;
    logic signed [W:0] sum;
    logic signed [W-1:0] nxt;

    // Form the widened sum and clamp it to the symmetric range.
    always_comb begin
        ext   = {acc[W-1], acc};
        stepx = {1'b0, step};
        sum   = down ? (ext - stepx) : (ext + stepx);
        if (sum > MAXV)      nxt = MAXV[W-1:0];
        else if (sum < MINV) nxt = MINV[W-1:0];
        else                 nxt = sum[W-1:0];
    end

    // Register the count: reset, clear, count, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (cnt)  acc <= nxt;
    end

    // R5: a clear leaves a zero count.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    // R4: no count request, no change.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt) |=> $stable(acc));
    // R10: the most negative code is never reached, so no wrap.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc != {1'b1, {(W-1){1'b0}}});
    // R3: a unit up-step below the top moves the count by exactly one.
    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt && !down && step == W'(1) && acc != MAXV[W-1:0])
        |=> (acc == $past(acc) + 1));
endmodule

// File: rtl/msr_result_reg.sv
// Module: msr_result_reg
// Captures the running count at conversion end, clamped to +/-LIMIT,
// and raises a one-cycle flag with the new value.
// Assumes LIMIT fits in RW-bit two's complement and AW >= RW.
module msr_result_reg
    import msr_acc_pkg::*;
#(
    parameter int AW    = ACC_W,
    parameter int RW    = RES_W,
    parameter int LIMIT = HARD_LIMIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [AW-1:0] acc,
    output logic [RW-1:0]        result,
    output logic                 fresh
);
    localparam logic signed [AW-1:0] POS_LIM = AW'(LIMIT);
    localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM;

    logic signed [AW-1:0] clamped;

    // Clamp the count to the hard overrange magnitude.
    always_comb begin
        if (acc > POS_LIM)      clamped = POS_LIM;
        else if (acc < NEG_LIM) clamped = NEG_LIM;
        else                    clamped = acc;
    end

    // Transfer on load; flag the cycle the new value appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            fresh  <= 1'b0;
        end else begin
            fresh <= load;
            if (load) result <= clamped[RW-1:0];
        end
    end

    // R6: result changes only through a transfer.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(result));
    // R9: the flag follows a transfer by exactly one edge.
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> fresh);
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !fresh);
    // R7: reported magnitude never exceeds the limit.
    p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(result) <= RW'(LIMIT)) && ($signed(result) >= -$signed(RW'(LIMIT))));
endmodule

// File: rtl/msr_result_acc.sv
// Module: msr_result_acc (top)
// Phase-weighted up/down accumulator feeding a clamped result register.
// Assumes the sequencer drives phase, cnt_en and cnt_down synchronously
// and pulses conv_start / conv_end for one clock each.
module msr_result_acc
    import msr_acc_pkg::*;
#(
    parameter int AW    = ACC_W,
    parameter int RW    = RES_W,
    parameter int LIMIT = HARD_LIMIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_start,
    input  logic               conv_end,
    input  logic [PHASE_W-1:0] phase,
    input  logic               cnt_en,
    input  logic               cnt_down,
    output logic [RW-1:0]      result,
    output logic               result_new
);
    logic [AW-1:0]        step_mag;
    logic                 step_hit;
    logic signed [AW-1:0] acc;
    logic                 do_cnt;

    msr_step_weight #(.W(AW)) u_weight (
        .phase_code (phase),
        .step_mag   (step_mag),
        .step_hit   (step_hit)
    );

    // Count only when enabled and a deintegrate phase is named.
    assign do_cnt = cnt_en && step_hit;

    msr_updown_acc #(.W(AW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (conv_start),
        .cnt   (do_cnt),
        .down  (cnt_down),
        .step  (step_mag),
        .acc   (acc)
    );

    msr_result_reg #(.AW(AW), .RW(RW), .LIMIT(LIMIT)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (conv_end),
        .acc    (acc),
        .result (result),
        .fresh  (result_new)
    );

    // R4: a non-counting phase code never produces a step.
    p_idle_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 || phase > 3'd4) |-> !step_hit);
    // R2: the first phase decodes to a weight of 512.
    p_coarse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |-> (step_mag == AW'(512)));
endmodule

// File: tb/msr_result_acc_bench.sv
module msr_result_acc_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       conv_start = 0, conv_end = 0, cnt_en = 0, cnt_down = 0;
    logic [2:0] phase = 0;
    logic [19:0] result;
    logic        result_new;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R1";
    // Behavioural reference state.
    longint m_acc = 0, m_res = 0;
    bit     m_new = 0;
    localparam longint ACC_MAX = 2097151;

    always #5 clk = ~clk;

    msr_result_acc u_msr_result_acc (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_end(conv_end),
        .phase(phase), .cnt_en(cnt_en), .cnt_down(cnt_down),
        .result(result), .result_new(result_new)
    );

    function automatic longint weight(input logic [2:0] p);
        case (p)
            3'd1: return 512;
            3'd2: return 64;
            3'd3: return 8;
            3'd4: return 1;
            default: return 0;
        endcase
    endfunction

    // Reference model: updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_res = 0; m_new = 0;
        end else begin
            m_new = conv_end;
            if (conv_end) m_res = (m_acc > 350440) ? 350440 : (m_acc < -350440) ? -350440 : m_acc;
            if (conv_start) m_acc = 0;
            else if (cnt_en && weight(phase) != 0) begin
                m_acc = cnt_down ? m_acc - weight(phase) : m_acc + weight(phase);
                if (m_acc > ACC_MAX) m_acc = ACC_MAX;
                if (m_acc < -ACC_MAX) m_acc = -ACC_MAX;
            end
        end
    end

    // Compare against the model on every falling edge (R6, R8, R9 always).
    always @(negedge clk) begin
        logic [19:0] exp_r;
        exp_r = 20'(m_res);
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s/R6/R8 result: actual %0d expected %0d", tag, $signed(result), m_res);
        end
        checks++;
        if (result_new !== m_new) begin
            errors++;
            $display("FAIL R9 result_new: actual %0b expected %0b", result_new, m_new);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input logic [2:0] p, input bit en, input bit dn, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            phase = p; cnt_en = en; cnt_down = dn;
        end
        @(negedge clk);
        cnt_en = 0; phase = 0;
    endtask

    task automatic pulse_end();
        @(negedge clk); conv_end = 1;
        @(negedge clk); conv_end = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); conv_start = 1;
        @(negedge clk); conv_start = 0;
    endtask

    task automatic expect_res(input string t, input longint v);
        @(negedge clk);
        checks++;
        if ($signed(result) != v) begin
            errors++;
            $display("FAIL %s directed: actual %0d expected %0d", t, $signed(result), v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        expect_res("R1", 0);
        rst_n = 1;
        // R2: coarse up-steps
        tag = "R2";
        pulse_start(); step(3'd1, 1, 0, 10); pulse_end();
        expect_res("R2", 5120);
        // R2/R8: coarse down gives a negative, polarity bit set
        tag = "R8";
        pulse_start(); step(3'd1, 1, 1, 3); pulse_end();
        expect_res("R8", -1536);
        checks++;
        if (result[19] !== 1'b1) begin
            errors++; $display("FAIL R8 polarity: actual %0b expected 1", result[19]);
        end
        // R3: finer phases
        tag = "R3";
        pulse_start(); step(3'd2, 1, 0, 3); step(3'd3, 1, 1, 5); step(3'd4, 1, 0, 7); pulse_end();
        expect_res("R3", 159);
        // R4: disabled clocks and idle codes do not count
        tag = "R4";
        pulse_start(); step(3'd1, 0, 0, 5); step(3'd0, 1, 0, 4);
        step(3'd5, 1, 0, 2); step(3'd6, 1, 1, 2); step(3'd7, 1, 0, 2); pulse_end();
        expect_res("R4", 0);
        // R5: start beats a same-cycle count
        tag = "R5";
        step(3'd1, 1, 0, 2);
        @(negedge clk); conv_start = 1; phase = 1; cnt_en = 1;
        @(negedge clk); conv_start = 0; cnt_en = 0; phase = 0;
        pulse_end();
        expect_res("R5", 0);
        // R6: transfer and clear in the same cycle
        tag = "R6";
        step(3'd2, 1, 0, 4);
        @(negedge clk); conv_start = 1; conv_end = 1;
        @(negedge clk); conv_start = 0; conv_end = 0;
        expect_res("R6", 256);
        pulse_end();
        expect_res("R6", 0);
        // R7: clamp both signs
        tag = "R7";
        pulse_start(); step(3'd1, 1, 0, 700); pulse_end();
        expect_res("R7", 350440);
        pulse_start(); step(3'd1, 1, 1, 700); pulse_end();
        expect_res("R7", -350440);
        // R10: saturate the count, then come back down
        tag = "R10";
        pulse_start(); step(3'd1, 1, 0, 4200); step(3'd1, 1, 1, 3500); pulse_end();
        expect_res("R10", 305151);
        pulse_start(); step(3'd1, 1, 1, 4200); step(3'd1, 1, 0, 3500); pulse_end();
        expect_res("R10", -305151);
        // Mixed sequence: model comparison every clock
        tag = "R3";
        for (int k = 0; k < 40; k++) begin
            pulse_start();
            for (int j = 0; j < 6; j++)
                step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 30)));
            pulse_end();
        end
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule